// File: doc/BRIEF.md
# Bang-Bang Integral Path Accumulator

This block forms the digital integral branch of a hybrid phase-locked loop. A flip-flop on the phase detector outputs decides once per reference edge whether the feedback clock arrived early or late. The block takes that one-bit decision at the full reference rate, together with a strobe that marks it valid. A 1-to-4 demultiplexer collects four consecutive decisions into a group. A slower, divided-rate update then sums each complete group and adds it into a wide signed accumulator.

Only the upper 14 bits of the 18-bit accumulator leave the block, as the oscillator frequency-control word. The four low bits average out the bang-bang dither before it reaches the oscillator. A shift input sets the integral gain in powers of two. A load input places the accumulator at a chosen starting value, so that lock can start close to the target frequency. Both the full-rate strobe and the divided-rate update are enables that run on one common clock.

Top module: `bbpd_int_acc`

## Requirements
- R1: While `rst_ni` is low, the accumulator is zero and `ctrl_o` reads 0.
- R2: A sign bit of 1 (late) counts as +1 and a sign bit of 0 (early) counts as -1. The four values of a complete group are summed, giving a result from -4 to +4.
- R3: Each `div_en_i` cycle adds the most recent unconsumed complete group to the accumulator. When `div_en_i` is high and no new complete group is waiting, the accumulator does not change. A partial group is never added.
- R4: The amount added is the group sum multiplied by 2^`shift_i`.
- R5: If an addition would take the accumulator above +131071, the accumulator holds at +131071 and does not wrap.
- R6: If an addition would take the accumulator below -131072, the accumulator holds at -131072 and does not wrap.
- R7: When `load_i` is high, the accumulator takes `load_val_i` at the next edge. This takes priority over `div_en_i`, and any complete group still waiting is discarded.
- R8: `ctrl_o` equals accumulator bits [17:4], read as a 14-bit two's-complement word.
- R9: `sign_i` has no effect in any cycle where `sign_vld_i` is low. Lane order follows only the strobed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the full-rate and divided-rate logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sign_i | input | 1 | Phase-error sign: 1 late, 0 early |
| sign_vld_i | input | 1 | Full-rate strobe that qualifies `sign_i` |
| div_en_i | input | 1 | Divided-rate update enable |
| shift_i | input | 3 | Integral gain exponent, 0 to 7 |
| load_i | input | 1 | Force the accumulator to `load_val_i` |
| load_val_i | input | 18 | Signed starting value for the accumulator |
| ctrl_o | output | 14 | Truncated frequency-control word |

## Verification
The step bound on the accumulator rests on `shift_i` staying within 0 to 7. It also assumes that each update adds at most one group of four signs. The bench changes `shift_i` only while `div_en_i` is low, and it always feeds signs in whole groups of four or fewer before an update. Saturation is reached by loading values close to the rails rather than by long runs, so that each clamp happens within a single step. The idle-hold property assumes that `div_en_i` is a single-cycle pulse per update. The bench follows that rule.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;
  localparam int unsigned LANES_DEF   = 4;
  localparam int unsigned ACC_W_DEF   = 18;
  localparam int unsigned OUT_W_DEF   = 14;
  localparam int unsigned SHIFT_W_DEF = 3;

  // signed width that holds -lanes..+lanes
  function automatic int unsigned sum_width(input int unsigned lanes);
    return $clog2(lanes + 1) + 1;
  endfunction
endpackage

// File: rtl/bbpd_demux.sv
module bbpd_demux #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sign_i,
  input  logic             sign_vld_i,
  input  logic             consume_i,
  input  logic             discard_i,
  output logic [LANES-1:0] grp_o,
  output logic             grp_vld_o
);
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [LANES-1:0] lanes_q, lanes_nxt;
  logic             done;

  always_comb begin
    lanes_nxt = lanes_q;
    lanes_nxt[idx_q] = sign_i;
  end

  assign done = sign_vld_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      lanes_q   <= '0;
      grp_o     <= '0;
      grp_vld_o <= 1'b0;
    end else begin
      if (sign_vld_i) begin
        lanes_q <= lanes_nxt;
        idx_q   <= done ? '0 : idx_q + 1'b1;
      end
      if (done) begin
        grp_o     <= lanes_nxt;
        grp_vld_o <= 1'b1;
      end else if (consume_i || discard_i) begin
        grp_vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bbpd_lane_sum.sv
module bbpd_lane_sum #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SUM_W = 4
) (
  input  logic [LANES-1:0]        grp_i,
  output logic signed [SUM_W-1:0] sum_o
);
  logic signed [SUM_W-1:0] term [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_term
    assign term[g] = grp_i[g] ? SUM_W'(1) : -SUM_W'(1);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < LANES; i++) sum_o = sum_o + term[i];
  end
endmodule

// File: rtl/bbpd_sat_acc.sv
module bbpd_sat_acc #(
  parameter int unsigned ACC_W   = 18,
  parameter int unsigned SUM_W   = 4,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    add_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    load_i,
  input  logic [ACC_W-1:0]        load_val_i,
  output logic [ACC_W-1:0]        acc_o
);
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] inc;
  logic signed [ACC_W:0]   wide;
  logic [ACC_W-1:0]        sat;

  assign inc  = ACC_W'(sum_i) <<< shift_i;
  assign wide = {acc_o[ACC_W-1], acc_o} + {inc[ACC_W-1], inc};

  always_comb begin
    if (wide[ACC_W] != wide[ACC_W-1]) sat = wide[ACC_W] ? NEG_LIM : POS_LIM;
    else                              sat = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= load_val_i;
    else if (add_i)  acc_o <= sat;
  end
endmodule

// File: rtl/bbpd_int_acc.sv
module bbpd_int_acc
  import bbpd_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned ACC_W   = ACC_W_DEF,
  parameter int unsigned OUT_W   = OUT_W_DEF,
  parameter int unsigned SHIFT_W = SHIFT_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sign_i,
  input  logic               sign_vld_i,
  input  logic               div_en_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               load_i,
  input  logic [ACC_W-1:0]   load_val_i,
  output logic [OUT_W-1:0]   ctrl_o
);
  localparam int unsigned SUM_W = sum_width(LANES);

  logic [LANES-1:0]        grp;
  logic                    grp_vld;
  logic                    add;
  logic signed [SUM_W-1:0] grp_sum;
  logic [ACC_W-1:0]        acc_q;

  assign add = div_en_i && grp_vld && !load_i;

  bbpd_demux #(.LANES(LANES)) u_demux (
    .clk_i, .rst_ni, .sign_i, .sign_vld_i,
    .consume_i (add),
    .discard_i (load_i),
    .grp_o     (grp),
    .grp_vld_o (grp_vld)
  );

  bbpd_lane_sum #(.LANES(LANES), .SUM_W(SUM_W)) u_sum (
    .grp_i (grp),
    .sum_o (grp_sum)
  );

  bbpd_sat_acc #(.ACC_W(ACC_W), .SUM_W(SUM_W), .SHIFT_W(SHIFT_W)) u_acc (
    .clk_i, .rst_ni,
    .add_i   (add),
    .sum_i   (grp_sum),
    .shift_i,
    .load_i,
    .load_val_i,
    .acc_o   (acc_q)
  );

  // low bits dropped to hide dither
  assign ctrl_o = acc_q[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/bbpd_int_acc_chk.sv
module bbpd_int_acc_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned ACC_W   = 18,
  parameter int unsigned SHIFT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_en_i,
  input logic             load_i,
  input logic [ACC_W-1:0] load_val_i,
  input logic             grp_vld_i,
  input logic [ACC_W-1:0] acc_i
);
  localparam int MAX_STEP = int'(LANES) * (2 ** ((2 ** SHIFT_W) - 1));

  logic [ACC_W-1:0]    past_acc;
  logic                past_load, past_ok;
  logic signed [ACC_W:0] delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_acc  <= '0;
      past_load <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      past_acc  <= acc_i;
      past_load <= load_i;
      past_ok   <= 1'b1;
    end
  end

  assign delta = $signed({acc_i[ACC_W-1], acc_i}) - $signed({past_acc[ACC_W-1], past_acc});

  // R1
  always @(negedge clk_i) if (!rst_ni) rst_zero_chk: assert (acc_i == '0);

  // R7
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_i == $past(load_val_i));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(div_en_i && grp_vld_i)) |=> $stable(acc_i));

  // R5 R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !past_load) |-> (delta <= MAX_STEP && delta >= -MAX_STEP));
endmodule

bind bbpd_int_acc bbpd_int_acc_chk #(.LANES(LANES), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) chk_i (
  .clk_i, .rst_ni, .div_en_i, .load_i, .load_val_i,
  .grp_vld_i (grp_vld),
  .acc_i     (acc_q)
);

// File: tb/bbpd_int_acc_tb_top.sv
module bbpd_int_acc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sign_i = 1'b0, sign_vld_i = 1'b0, div_en_i = 1'b0, load_i = 1'b0;
  logic [2:0]  shift_i = '0;
  logic [17:0] load_val_i = '0;
  logic [13:0] ctrl_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bbpd_int_acc dut_i (.*);

  function automatic logic [13:0] exp_ctrl(input int v);
    return 14'((v >>> 4) & 16'h3FFF);
  endfunction

  task automatic check(input string req, input logic [13:0] exp);
    n_chk++;
    if (ctrl_o !== exp) begin
      n_bad++;
      $display("FAIL %s: ctrl_o=%h expected %h", req, ctrl_o, exp);
    end
  endtask

  task automatic push4(input logic [3:0] s);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); sign_i = s[i]; sign_vld_i = 1'b1;
    end
    @(negedge clk_i); sign_vld_i = 1'b0; sign_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i); div_en_i = 1'b1;
    @(negedge clk_i); div_en_i = 1'b0;
  endtask

  task automatic load(input int v);
    @(negedge clk_i); load_i = 1'b1; load_val_i = 18'(v);
    @(negedge clk_i); load_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 14'h0);
  endtask

  task automatic t_sign_map();
    shift_i = 3'd4; load(0);
    push4(4'b1111); tick(); check("R2 all late", exp_ctrl(64));
    push4(4'b0000); tick(); check("R2 all early", exp_ctrl(0));
    push4(4'b0101); tick(); check("R2 balanced", exp_ctrl(0));
    push4(4'b0111); tick(); check("R2 three late", exp_ctrl(32));
  endtask

  task automatic t_trunc();
    shift_i = 3'd0; load(15);
    check("R8 below lsb", 14'h0);
    push4(4'b1111); tick(); check("R8 carry into lsb", 14'h1);
    load(-1); check("R8 negative", 14'h3FFF);
  endtask

  task automatic t_group();
    shift_i = 3'd4; load(0);
    tick(); check("R3 no group", exp_ctrl(0));
    // three strobes, then noise with strobe low, then the fourth
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); sign_i = 1'b1; sign_vld_i = 1'b1;
    end
    @(negedge clk_i); sign_vld_i = 1'b0; sign_i = 1'b0;
    @(negedge clk_i); sign_i = 1'b0;
    @(negedge clk_i); sign_i = 1'b1; div_en_i = 1'b1;
    @(negedge clk_i); div_en_i = 1'b0; sign_i = 1'b0;
    check("R3 partial group held", exp_ctrl(0));
    check("R9 unstrobed sign ignored", exp_ctrl(0));
    @(negedge clk_i); sign_i = 1'b1; sign_vld_i = 1'b1;
    @(negedge clk_i); sign_vld_i = 1'b0; sign_i = 1'b0;
    tick(); check("R9 lane order from strobes", exp_ctrl(64));
    tick(); check("R3 group used once", exp_ctrl(64));
  endtask

  task automatic t_shift();
    load(0); shift_i = 3'd7;
    push4(4'b1111); tick(); check("R4 shift 7", exp_ctrl(512));
    shift_i = 3'd5;
    push4(4'b0001); tick(); check("R4 shift 5", exp_ctrl(512 - 64));
  endtask

  task automatic t_sat();
    shift_i = 3'd7; load(131071);
    push4(4'b1111); tick(); check("R5 upper clamp", exp_ctrl(131071));
    load(131000);
    push4(4'b1111); tick(); check("R5 clamp from near", exp_ctrl(131071));
    load(-131072);
    push4(4'b0000); tick(); check("R6 lower clamp", exp_ctrl(-131072));
    load(-131000);
    push4(4'b0000); tick(); check("R6 clamp from near", exp_ctrl(-131072));
  endtask

  task automatic t_load();
    shift_i = 3'd4; load(0);
    push4(4'b1111);
    @(negedge clk_i); load_i = 1'b1; load_val_i = 18'(1600); div_en_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0; div_en_i = 1'b0;
    check("R7 load wins", exp_ctrl(1600));
    tick(); check("R7 pending group dropped", exp_ctrl(1600));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_sign_map();
    t_trunc();
    t_group();
    t_shift();
    t_sat();
    t_load();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule